// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Master

This block programs an external clock synthesizer over a three-wire serial link: a data line, a clock line and a latch strobe. When a start request is accepted, it captures a set of synthesizer setting fields and packs them into one 24-bit programming word. It then sends the word serially, one bit per clock pulse. All line timing is built from a settle delay unit, which is a parameterised number of system clock cycles.

After the clock line is released high, the block reads back the clock line. A slave that holds the clock low stretches the bit. The block polls once per delay unit, up to a parameterised poll limit. If the limit is reached, a sticky timeout flag is set and the transfer continues anyway. After the last bit, a strobe pulse tells the synthesizer to take the new word. The block signals the end of the transfer with a one-cycle done pulse.

Top module: `clk_synth_loader`

## Requirements
- R1: The word is sent most significant bit first, 24 bits per transfer. The 24-bit word is `{cp_sel_i[1:0], ttl_i, fsel_i[1:0], scale_i[2:0], vdiv_i[8:0], rdiv_i[6:0]}`. Bit 23 is `cp_sel_i[1]` and bit 0 is `rdiv_i[0]`. The fields are captured when start is accepted.
- R2: The data line changes only while the clock line is low. Within each bit, the block waits one delay unit, drives data, waits one delay unit, then raises the clock. The slave samples data on the rising clock edge.
- R3: With no clock stretching, the time from the start-accept edge to the done pulse is exactly 100 delay units (100 × DLY_CYC cycles). This is four units per bit plus four units for the strobe phase.
- R4: If the clock readback is low one delay unit after the clock is raised, the block adds delay units, one per poll, until the readback goes high. The bit is still delivered correctly, and the timeout flag stays clear as long as fewer than MAX_POLL polls are needed.
- R5: If the readback stays low, the block stops polling after exactly MAX_POLL polls (MAX_POLL extra delay units). It then sets `timeout_o` and completes the transfer.
- R6: One delay unit after the last clock fall, `latch_o` rises. It stays high for exactly two delay units, with the clock line low throughout. `done_o` follows one delay unit after `latch_o` falls.
- R7: `timeout_o` is sticky: it stays set after the transfer ends, and it is cleared only when the next start is accepted.
- R8: A start request while `busy_o` is high is ignored. The word in flight, the transfer length and the number of done pulses are not changed.
- R9: `busy_o` is high from the start-accept edge until the done pulse. `done_o` is high for exactly one cycle per transfer.
- R10: After reset and whenever the block is idle, `sdat_o`, `sclk_o` and `latch_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer request, sampled while idle |
| cp_sel_i | input | 2 | Word bits 23:22 |
| ttl_i | input | 1 | Word bit 21 |
| fsel_i | input | 2 | Word bits 20:19 |
| scale_i | input | 3 | Word bits 18:16 |
| vdiv_i | input | 9 | Word bits 15:7 |
| rdiv_i | input | 7 | Word bits 6:0 |
| sclk_rd_i | input | 1 | Readback of the serial clock line |
| sdat_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock line |
| latch_o | output | 1 | Latch strobe to the synthesizer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| timeout_o | output | 1 | Sticky clock-stretch timeout flag |

## Verification
Each sequencing fault shows up at the line pins within one transfer:
- A wrong bit index or shift shows up as a wrong captured word at the 24th clock rise.
- A timer or state slip changes the start-to-done cycle count, or the width and placement of the strobe, by whole delay units.
- A bad poll counter changes the transfer length by an exact number of units, or the state of `timeout_o`, once the readback is held low.
- A start leaking through while busy changes the captured word or adds a second done pulse.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam int WORD_W = 24;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_RISE,
    ST_STRETCH,
    ST_TAIL,
    ST_STB_LEAD,
    ST_STB_HOLD1,
    ST_STB_HOLD2,
    ST_STB_TAIL
  } state_e;
endpackage

// File: rtl/csl_word_pack.sv
module csl_word_pack
  import csl_pkg::*;
(
  input  logic [1:0]        cp_sel_i,
  input  logic              ttl_i,
  input  logic [1:0]        fsel_i,
  input  logic [2:0]        scale_i,
  input  logic [8:0]        vdiv_i,
  input  logic [6:0]        rdiv_i,
  output logic [WORD_W-1:0] word_o
);
  logic [7:0] byte_hi, byte_mid, byte_lo;

  always_comb begin
    byte_hi  = {cp_sel_i, ttl_i, fsel_i, scale_i};
    byte_mid = vdiv_i[8:1];
    byte_lo  = {vdiv_i[0], rdiv_i};
    word_o   = {byte_hi, byte_mid, byte_lo};
  end
endmodule

// File: rtl/csl_unit_timer.sv
module csl_unit_timer #(
  parameter int DLY_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign expire_o = (cnt_q == CW'(DLY_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_synth_loader.sv
module clk_synth_loader
  import csl_pkg::*;
#(
  parameter int DLY_CYC  = 4,
  parameter int MAX_POLL = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] cp_sel_i,
  input  logic       ttl_i,
  input  logic [1:0] fsel_i,
  input  logic [2:0] scale_i,
  input  logic [8:0] vdiv_i,
  input  logic [6:0] rdiv_i,
  input  logic       sclk_rd_i,
  output logic       sdat_o,
  output logic       sclk_o,
  output logic       latch_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o
);
  localparam int BW = $clog2(WORD_W);
  localparam int PW = $clog2(MAX_POLL + 1);

  state_e            state_q;
  logic [WORD_W-1:0] word_d, sh_q;
  logic [BW-1:0]     bit_q;
  logic [PW-1:0]     poll_q;
  logic              unit_end;

  csl_word_pack u_pack (
    .cp_sel_i (cp_sel_i),
    .ttl_i    (ttl_i),
    .fsel_i   (fsel_i),
    .scale_i  (scale_i),
    .vdiv_i   (vdiv_i),
    .rdiv_i   (rdiv_i),
    .word_o   (word_d)
  );

  csl_unit_timer #(.DLY_CYC(DLY_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i ((state_q == ST_IDLE) || unit_end),
    .expire_o  (unit_end)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      bit_q     <= '0;
      poll_q    <= '0;
      sdat_o    <= 1'b0;
      sclk_o    <= 1'b0;
      latch_o   <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          sh_q      <= word_d;
          bit_q     <= '0;
          timeout_o <= 1'b0;
          state_q   <= ST_LEAD;
        end
        ST_LEAD: if (unit_end) begin
          sdat_o  <= sh_q[WORD_W-1];
          state_q <= ST_DATA;
        end
        ST_DATA: if (unit_end) begin
          sclk_o  <= 1'b1;
          state_q <= ST_RISE;
        end
        ST_RISE: if (unit_end) begin
          poll_q  <= '0;
          state_q <= sclk_rd_i ? ST_TAIL : ST_STRETCH;
        end
        ST_STRETCH: if (unit_end) begin
          if (sclk_rd_i) begin
            state_q <= ST_TAIL;
          end else if (poll_q == PW'(MAX_POLL - 1)) begin
            timeout_o <= 1'b1;
            state_q   <= ST_TAIL;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        ST_TAIL: if (unit_end) begin
          sclk_o <= 1'b0;
          sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
          if (bit_q == BW'(WORD_W - 1)) begin
            state_q <= ST_STB_LEAD;
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LEAD;
          end
        end
        ST_STB_LEAD: if (unit_end) begin
          sdat_o  <= 1'b0;
          latch_o <= 1'b1;
          state_q <= ST_STB_HOLD1;
        end
        ST_STB_HOLD1: if (unit_end) state_q <= ST_STB_HOLD2;
        ST_STB_HOLD2: if (unit_end) begin
          latch_o <= 1'b0;
          state_q <= ST_STB_TAIL;
        end
        ST_STB_TAIL: if (unit_end) begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csl_checker.sv
module csl_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sdat_o,
  input logic sclk_o,
  input logic latch_o,
  input logic busy_o,
  input logic done_o
);
  AST_IDLE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sdat_o && !sclk_o && !latch_o)); // R10

  AST_DATA_STABLE_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdat_o)); // R2

  AST_LATCH_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !sclk_o); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
endmodule

bind clk_synth_loader csl_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sdat_o  (sdat_o),
  .sclk_o  (sclk_o),
  .latch_o (latch_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/clk_synth_loader_tb.sv
module clk_synth_loader_tb;
  localparam int CLK_PER = 10;
  localparam int DLY     = 3;
  localparam int NPOLL   = 6;

  logic       clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [1:0] cp_sel_i = '0, fsel_i = '0;
  logic       ttl_i = 1'b0;
  logic [2:0] scale_i = '0;
  logic [8:0] vdiv_i = '0;
  logic [6:0] rdiv_i = '0;
  logic       sclk_rd_i;
  logic       sdat_o, sclk_o, latch_o, busy_o, done_o, timeout_o;

  int cmp = 0, bad = 0, cyc = 0;
  int hold = 0, hi_cyc = 0, nbits = 0, stuck_idx = -1;
  int lat_w = 0, last_fall = 0, lat_rise = 0, lat_fall = 0, n_done = 0, r2_viol = 0;
  logic [23:0] cap = '0;
  logic prev_sclk = 1'b0, prev_lat = 1'b0, prev_sdat = 1'b0;
  int t0 = 0, t1 = 0;

  clk_synth_loader #(.DLY_CYC(DLY), .MAX_POLL(NPOLL)) u_dut (.*);

  always #(CLK_PER/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  assign sclk_rd_i = sclk_o && (hi_cyc >= hold) && !(stuck_idx >= 0 && nbits == stuck_idx + 1);

  always @(negedge clk_i) begin
    hi_cyc <= sclk_o ? hi_cyc + 1 : 0;
    if (sclk_o && !prev_sclk) begin cap <= {cap[22:0], sdat_o}; nbits <= nbits + 1; end
    if (sclk_o && prev_sclk && sdat_o != prev_sdat) r2_viol <= r2_viol + 1;
    if (!sclk_o && prev_sclk) last_fall <= cyc;
    if (latch_o) lat_w <= lat_w + 1;
    if (latch_o && !prev_lat) lat_rise <= cyc;
    if (!latch_o && prev_lat) lat_fall <= cyc;
    if (done_o) n_done <= n_done + 1;
    prev_sclk <= sclk_o; prev_lat <= latch_o; prev_sdat <= sdat_o;
  end

  function automatic logic [23:0] exp_word(logic [1:0] c, logic t, logic [1:0] f,
                                           logic [2:0] s, logic [8:0] v, logic [6:0] r);
    logic [7:0] b1, b2, b3;
    b1 = 8'(c) << 6 | 8'(t) << 5 | 8'(f) << 3 | 8'(s);
    b2 = v[8:1];
    b3 = {v[0], 7'h0} | {1'b0, r};
    return {b1, b2, b3};
  endfunction

  task automatic chk(string req, int act, int expv);
    cmp++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic xfer(input logic [1:0] c, input logic t, input logic [1:0] f, input logic [2:0] s,
                      input logic [8:0] v, input logic [6:0] r, input bit inject);
    logic [23:0] ew;
    ew = exp_word(c, t, f, s, v, r);
    @(negedge clk_i);
    cp_sel_i = c; ttl_i = t; fsel_i = f; scale_i = s; vdiv_i = v; rdiv_i = r;
    nbits = 0; lat_w = 0; n_done = 0; r2_viol = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    t0 = cyc;
    chk("R9 busy after start", int'(busy_o), 1);
    chk("R7 timeout cleared at start", int'(timeout_o), 0);
    while (!done_o && (cyc - t0) < 20000) begin
      @(negedge clk_i);
      if (inject && (cyc - t0) == 40) begin
        start_i = 1'b1; cp_sel_i = ~c; vdiv_i = ~v; rdiv_i = ~r;
      end else start_i = 1'b0;
    end
    t1 = cyc;
    chk("R1 word", int'(cap), int'(ew));
    chk("R1 bit count", nbits, 24);
    chk("R2 data change while clock high", r2_viol, 0);
    chk("R6 latch width", lat_w, 2 * DLY);
    chk("R6 fall to latch", lat_rise - last_fall, DLY);
    chk("R6 latch to done", t1 - lat_fall, DLY);
    repeat (4) @(negedge clk_i);
    chk("R9 done pulses", n_done, 1);
    chk("R10 idle lines", int'({sdat_o, sclk_o, latch_o, busy_o}), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R10 reset sdat", int'(sdat_o), 0);
    chk("R10 reset sclk", int'(sclk_o), 0);
    chk("R10 reset latch", int'(latch_o), 0);
    chk("R9 reset busy", int'(busy_o), 0);
    rst_ni = 1'b1;

    // R3 directed patterns, no stretch
    hold = 0;
    xfer(2'b11, 1'b1, 2'b11, 3'b111, 9'h1FF, 7'h7F, 1'b0);
    chk("R3 duration all ones", t1 - t0, 100 * DLY);
    xfer(2'b10, 1'b0, 2'b01, 3'b101, 9'h101, 7'h40, 1'b0);
    chk("R3 duration", t1 - t0, 100 * DLY);
    chk("R4 no timeout", int'(timeout_o), 0);

    // R5 one bit stuck low, R7 sticky
    stuck_idx = 9;
    xfer(2'b01, 1'b1, 2'b10, 3'b010, 9'h0AA, 7'h15, 1'b0);
    chk("R5 duration stuck", t1 - t0, (100 + NPOLL) * DLY);
    chk("R5 timeout set", int'(timeout_o), 1);
    chk("R7 timeout sticky idle", int'(timeout_o), 1);
    stuck_idx = -1;

    // R8 start while busy
    xfer(2'b00, 1'b0, 2'b00, 3'b011, 9'h155, 7'h2A, 1'b1);
    chk("R8 duration unchanged", t1 - t0, 100 * DLY);
    chk("R7 timeout stays clear", int'(timeout_o), 0);

    // R4 random fields with bounded stretch
    for (int i = 0; i < 8; i++) begin
      hold = $urandom_range(0, 3 * DLY);
      xfer(2'($urandom), 1'($urandom), 2'($urandom), 3'($urandom), 9'($urandom), 7'($urandom), 1'b0);
      if (hold <= DLY) chk("R3 random duration", t1 - t0, 100 * DLY);
      else chk("R4 stretch lengthens", int'((t1 - t0) > 100 * DLY), 1);
      chk("R4 no timeout", int'(timeout_o), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    bad++; cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
    $finish;
  end
endmodule